// File: doc/BRIEF.md
# Line-Targeted Ancillary Packet Inserter

The block sits in a 10-bit parallel video path that carries one word per clock, with timing reference codes framing each line. It finds the end-of-active-video code, keeps a line count that restarts at each frame, and on up to two programmed line numbers it writes prepared ancillary words into that line's horizontal blanking. An upstream buffer holds the words. It shows its head word on a read-data input, reports how many words it holds, and drops the head word when the block pulses its pop output.

New words can be placed straight after the timing code, where they overwrite blanking. They can also follow any packets the line already carries, which are found by their data flag and skipped using their data count. Insertion is armed at a frame boundary and stays armed when the enable is dropped. Only the bypass mode stops it, and after bypass is left a fixed hold-off passes before it can arm again. A placement that would run past the blanking region is skipped and reported by a one-cycle flag.

Top module: `anc_line_inserter`

## Requirements
- R1: When the enable input goes high, insertion is armed only at the next frame boundary. No line of the current frame receives words.
- R2: The frame boundary is an end-of-active-video code with field bit 0 (bit 8 of the code word) that follows one with field bit 1; that line is number 1. Every other end code adds one to the line number. Insertion happens on every line whose number equals either 11-bit target, in every frame.
- R3: Once armed, insertion continues after the enable input is cleared.
- R4: Mode value 11b is bypass. The block then reads nothing, disarms, and passes the stream unchanged.
- R5: After the mode leaves bypass, arming is blocked for RESUME_CYC clock cycles. At the end of that wait the block arms at once if enable is high, without waiting for a frame boundary.
- R6: With the direct-select input high, inserted words occupy the blanking words that start right after the end code's fourth word, replacing them.
- R7: With direct-select low, existing packets are assumed to be contiguous from the first blanking word. Each one is recognised by the word sequence 000h, 3FFh, 3FFh and is counted as its data-count field (bits 7:0 of the sixth word) plus 7 words. New words follow the last existing packet.
- R8: If the start position plus the word count exceeds HBLANK words, nothing is read, the line is left unchanged, and the overflow output pulses for one cycle. A placement that ends exactly on the last blanking word is carried out.
- R9: The count sampled at the end code decides how many words are inserted on that line. All of those words are popped and output in buffer order, and a count of zero inserts nothing.
- R10: Words that are not replaced leave the block unchanged, 4 clock cycles after they enter. Under reset the video output, pop and overflow are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | 10 | Incoming video word |
| vid_o | output | 10 | Outgoing video word, 4 cycles later |
| ins_en_i | input | 1 | Insertion enable request |
| op_mode_i | input | 2 | Operating mode; 11b is bypass |
| direct_sel_i | input | 1 | 1: place after the timing code; 0: after existing packets |
| tgt_line_a_i | input | LINE_W | First target line number |
| tgt_line_b_i | input | LINE_W | Second target line number |
| buf_word_i | input | 10 | Head word of the upstream buffer |
| buf_avail_i | input | CNT_W | Words held in the upstream buffer |
| buf_pop_o | output | 1 | Consume the head word this cycle |
| ovf_o | output | 1 | One-cycle pulse when a placement is skipped |

## Verification
Lines are built with zero to two existing packets of random length, and buffer fills are random, including empty. Direct and append placement are therefore both tried against blanking that is already partly occupied, which separates a correct skip over existing packets from an off-by-one in the length arithmetic. Directed frames cover several cases. An enable raised mid-frame separates arming at the frame boundary from arming at once. Dropping the enable separates a held arm from a level-sensitive one. A fill that ends on the last blanking word and a fill one word larger separate the inclusive size limit from an exclusive one. A bypass exit followed by lines before and after the hold-off separates the resume timing from plain frame-boundary arming.

// File: rtl/anc_ins_pkg.sv
package anc_ins_pkg;

    localparam int WORD_W = 10;
    localparam logic [WORD_W-1:0] WORD_ONES = '1;
    localparam logic [WORD_W-1:0] WORD_ZERO = '0;
    localparam logic [1:0] MODE_BYPASS = 2'b11;
    localparam int PKT_HDR_SKIP = 4;  // flag words 2,3 plus two id words before the count

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_HDR,
        ST_BODY,
        ST_INS
    } slot_state_e;

    typedef struct packed {
        logic f;
        logic h;
    } trs_flags_t;

    function automatic trs_flags_t decode_xyz(input word_t w);
        trs_flags_t r;
        r.f = w[8];
        r.h = w[6];
        return r;
    endfunction

    function automatic logic is_trs_lead(input word_t a, input word_t b, input word_t c);
        return (a == WORD_ONES) && (b == WORD_ZERO) && (c == WORD_ZERO);
    endfunction

    function automatic logic is_data_flag(input word_t a, input word_t b, input word_t c);
        return (a == WORD_ZERO) && (b == WORD_ONES) && (c == WORD_ONES);
    endfunction

endpackage

// File: rtl/anc_trs_pipe.sv
module anc_trs_pipe
    import anc_ins_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t din,
    output word_t head,
    output word_t look1,
    output word_t look2,
    output logic  head_eav,
    output logic  head_f
);
    word_t s0, s1, s2;
    logic  t0, t1, t2;
    trs_flags_t fl;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0 <= '0; s1 <= '0; s2 <= '0;
            t0 <= 1'b0; t1 <= 1'b0; t2 <= 1'b0;
        end else begin
            s0 <= din;
            s1 <= s0;
            s2 <= s1;
            t0 <= is_trs_lead(s2, s1, s0);  // tags the word entering now as a code word
            t1 <= t0;
            t2 <= t1;
        end
    end

    always_comb begin
        fl       = decode_xyz(s2);
        head     = s2;
        look1    = s1;
        look2    = s0;
        head_eav = t2 && fl.h;
        head_f   = fl.f;
    end

    // R10: a tagged code word is always preceded by the zero lead word
    assert_tag_lead_R10: assert property (@(posedge clk) disable iff (rst)
        head_eav |-> $past(s2) == WORD_ZERO);

endmodule

// File: rtl/anc_line_arm.sv
module anc_line_arm
    import anc_ins_pkg::*;
#(
    parameter int LINE_W     = 11,
    parameter int RESUME_CYC = 2200
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              head_eav,
    input  logic              head_f,
    input  logic              en_i,
    input  logic              bypass_i,
    input  logic [LINE_W-1:0] tgt_a,
    input  logic [LINE_W-1:0] tgt_b,
    output logic              line_hit
);
    localparam int HOLD_W = $clog2(RESUME_CYC + 1);

    logic [LINE_W-1:0] line_q, line_nxt;
    logic [HOLD_W-1:0] holdoff;
    logic prev_f, armed, byp_q, boundary, hold_done, arm_now;

    always_comb begin
        boundary  = head_eav && prev_f && !head_f;
        line_nxt  = boundary ? LINE_W'(1) : line_q + 1'b1;
        hold_done = (holdoff == '0);
        arm_now   = armed || (boundary && en_i && hold_done);
        line_hit  = head_eav && !bypass_i && arm_now &&
                    ((line_nxt == tgt_a) || (line_nxt == tgt_b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            prev_f  <= 1'b0;
            armed   <= 1'b0;
            holdoff <= '0;
            byp_q   <= 1'b0;
        end else begin
            byp_q <= bypass_i;
            if (head_eav) begin
                line_q <= line_nxt;
                prev_f <= head_f;
            end
            if (bypass_i) begin
                armed   <= 1'b0;
                holdoff <= '0;
            end else if (byp_q) begin
                holdoff <= HOLD_W'(RESUME_CYC);
            end else begin
                if (!hold_done) begin
                    holdoff <= holdoff - 1'b1;
                    if (holdoff == HOLD_W'(1) && en_i)
                        armed <= 1'b1;
                end
                if (boundary && en_i && hold_done)
                    armed <= 1'b1;
            end
        end
    end

    assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (holdoff != '0) |-> !line_hit);
    assert_arm_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && !bypass_i) |=> armed);
    assert_bypass_disarms_R4: assert property (@(posedge clk) disable iff (rst)
        bypass_i |=> !armed);

endmodule

// File: rtl/anc_slot_fsm.sv
module anc_slot_fsm
    import anc_ins_pkg::*;
#(
    parameter int HBLANK = 268,
    parameter int CNT_W  = 10
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass_i,
    input  logic             direct_i,
    input  logic             line_hit,
    input  logic             head_eav,
    input  word_t            head,
    input  word_t            look1,
    input  word_t            look2,
    input  logic [CNT_W-1:0] avail,
    output logic             ins_now,
    output logic             ovf_o
);
    localparam int POS_W = $clog2(HBLANK + 1);
    localparam int SUM_W = ((POS_W > CNT_W) ? POS_W : CNT_W) + 1;

    slot_state_e       state;
    logic [POS_W-1:0]  pos;
    logic [CNT_W-1:0]  left;
    logic [8:0]        cnt;
    logic              dir_q, flag_here, place_try, fits;
    logic [SUM_W-1:0]  span;

    always_comb begin
        flag_here = is_data_flag(head, look1, look2);
        place_try = (state == ST_SCAN) && !(!dir_q && flag_here);
        span      = SUM_W'(pos) + SUM_W'(left);
        fits      = span <= SUM_W'(HBLANK);
        ins_now   = !bypass_i && !head_eav &&
                    ((state == ST_INS) || (place_try && fits));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pos   <= '0;
            left  <= '0;
            cnt   <= '0;
            dir_q <= 1'b0;
            ovf_o <= 1'b0;
        end else begin
            ovf_o <= 1'b0;
            if (head_eav)
                pos <= '0;
            else if (pos != POS_W'(HBLANK))
                pos <= pos + 1'b1;

            if (bypass_i) begin
                state <= ST_IDLE;
            end else if (head_eav) begin
                if (line_hit && avail != '0) begin
                    state <= ST_SCAN;
                    left  <= avail;
                    dir_q <= direct_i;
                end else begin
                    state <= ST_IDLE;
                end
            end else begin
                unique case (state)
                    ST_SCAN: begin
                        if (!dir_q && flag_here) begin
                            state <= ST_HDR;
                            cnt   <= 9'(PKT_HDR_SKIP);
                        end else if (fits) begin
                            left  <= left - 1'b1;
                            state <= (left == CNT_W'(1)) ? ST_IDLE : ST_INS;
                        end else begin
                            ovf_o <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                    ST_HDR: begin
                        if (cnt == '0) begin
                            cnt   <= {1'b0, head[7:0]} + 9'd1;  // user words plus checksum
                            state <= ST_BODY;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_BODY: begin
                        if (cnt == 9'd1) state <= ST_SCAN;
                        else             cnt   <= cnt - 1'b1;
                    end
                    ST_INS: begin
                        left <= left - 1'b1;
                        if (left == CNT_W'(1)) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_in_blank_R8: assert property (@(posedge clk) disable iff (rst)
        ins_now |-> (pos < POS_W'(HBLANK)));
    assert_ovf_no_read_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !ins_now);
    assert_direct_start_R6: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SCAN) && dir_q && !head_eav) |-> (pos == '0));

endmodule

// File: rtl/anc_line_inserter.sv
module anc_line_inserter
    import anc_ins_pkg::*;
#(
    parameter int HBLANK     = 268,
    parameter int RESUME_CYC = 2200,
    parameter int LINE_W     = 11,
    parameter int CNT_W      = 10
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [9:0]        vid_i,
    output logic [9:0]        vid_o,
    input  logic              ins_en_i,
    input  logic [1:0]        op_mode_i,
    input  logic              direct_sel_i,
    input  logic [LINE_W-1:0] tgt_line_a_i,
    input  logic [LINE_W-1:0] tgt_line_b_i,
    input  logic [9:0]        buf_word_i,
    input  logic [CNT_W-1:0]  buf_avail_i,
    output logic              buf_pop_o,
    output logic              ovf_o
);
    word_t head, look1, look2;
    logic  head_eav, head_f, line_hit, ins_now, bypass;

    assign bypass = (op_mode_i == MODE_BYPASS);

    anc_trs_pipe u_pipe (
        .clk(clk), .rst(rst), .din(vid_i),
        .head(head), .look1(look1), .look2(look2),
        .head_eav(head_eav), .head_f(head_f)
    );

    anc_line_arm #(.LINE_W(LINE_W), .RESUME_CYC(RESUME_CYC)) u_arm (
        .clk(clk), .rst(rst), .head_eav(head_eav), .head_f(head_f),
        .en_i(ins_en_i), .bypass_i(bypass),
        .tgt_a(tgt_line_a_i), .tgt_b(tgt_line_b_i), .line_hit(line_hit)
    );

    anc_slot_fsm #(.HBLANK(HBLANK), .CNT_W(CNT_W)) u_slot (
        .clk(clk), .rst(rst), .bypass_i(bypass), .direct_i(direct_sel_i),
        .line_hit(line_hit), .head_eav(head_eav),
        .head(head), .look1(look1), .look2(look2),
        .avail(buf_avail_i), .ins_now(ins_now), .ovf_o(ovf_o)
    );

    assign buf_pop_o = ins_now;

    always_ff @(posedge clk) begin
        if (rst) vid_o <= '0;
        else     vid_o <= ins_now ? buf_word_i : head;
    end

    assert_bypass_no_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (bypass && $past(bypass)) |-> !buf_pop_o);

endmodule

// File: tb/anc_line_inserter_tb_top.sv
module anc_line_inserter_tb_top;
    localparam int HB = 40, RES = 150, ACT = 20, LW = 11, CW = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, en, dsel, pop, ovf;
    logic [9:0] vin, vout, bword;
    logic [1:0] mode;
    logic [LW-1:0] ta, tb;
    logic [CW-1:0] avail;

    anc_line_inserter #(.HBLANK(HB), .RESUME_CYC(RES), .LINE_W(LW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .vid_i(vin), .vid_o(vout), .ins_en_i(en),
        .op_mode_i(mode), .direct_sel_i(dsel), .tgt_line_a_i(ta), .tgt_line_b_i(tb),
        .buf_word_i(bword), .buf_avail_i(avail), .buf_pop_o(pop), .ovf_o(ovf)
    );

    int checks = 0, errors = 0, cyc = 0, line_mis = 0, ovf_seen = 0, g = 0, resume_g = 0;
    bit pend = 0, armed_m = 0, resume_ok = 1, pend_res = 0, in_byp = 0, prev_f_m = 0;
    logic [9:0] q[$];
    logic [9:0] hist[8];

    function automatic logic [9:0] xyz(input bit f, input bit h);
        return {1'b1, f, 1'b0, h, h, f ^ h, f, f ^ h, 2'b00};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] w, input logic [9:0] e);
        logic [9:0] tmp;
        @(negedge clk);
        if (cyc >= 4 && vout !== hist[(cyc - 4) % 8]) line_mis++;
        if (ovf) ovf_seen++;
        if (pend && q.size() > 0) tmp = q.pop_front();
        pend  = pop;
        bword = (q.size() > 0) ? q[0] : 10'h000;
        avail = CW'(q.size());
        vin   = w;
        hist[cyc % 8] = e;
        cyc++;
    endtask

    task automatic do_line(input int L, input bit en_v, input logic [1:0] mode_v, input bit dir_v,
                           input int n, input int npk, input string tag);
        logic [9:0] blk[HB];
        logic [9:0] ex[HB];
        int e_len, dc, p;
        bit f, active, fits;
        string req;
        f = (L >= 4);
        en = en_v; mode = mode_v; dsel = dir_v;
        // reference arming model
        if (mode_v == 2'b11) begin
            armed_m = 0; resume_ok = 0; pend_res = 0; in_byp = 1;
        end else if (in_byp) begin
            in_byp = 0; pend_res = 1; resume_g = g + 3;
        end
        if (pend_res && g >= resume_g) begin
            pend_res = 0; resume_ok = 1;
            if (en_v) armed_m = 1;
        end
        if (L == 1 && prev_f_m && en_v && resume_ok && mode_v != 2'b11) armed_m = 1;
        prev_f_m = f;
        active = armed_m && mode_v != 2'b11 && (L == int'(ta) || L == int'(tb)) && n > 0;
        // existing packets then blanking filler
        e_len = 0;
        for (int k = 0; k < npk; k++) begin
            dc = $urandom_range(0, 6);
            blk[e_len] = 10'h000; blk[e_len+1] = 10'h3FF; blk[e_len+2] = 10'h3FF;
            blk[e_len+3] = 10'($urandom_range(256, 767));
            blk[e_len+4] = 10'($urandom_range(256, 767));
            blk[e_len+5] = 10'(dc);
            for (int u = 0; u < dc; u++) blk[e_len+6+u] = 10'($urandom_range(256, 767));
            blk[e_len+6+dc] = 10'($urandom_range(256, 767));
            e_len += dc + 7;
        end
        for (int i = e_len; i < HB; i++) blk[i] = (i % 2 == 0) ? 10'h200 : 10'h040;
        q.delete();
        for (int i = 0; i < n; i++) q.push_back(10'($urandom_range(16, 1007)));
        p = dir_v ? 0 : e_len;
        fits = (p + n) <= HB;
        for (int i = 0; i < HB; i++) ex[i] = blk[i];
        if (active && fits) for (int i = 0; i < n; i++) ex[p+i] = q[i];
        req = tag;
        if (req == "") req = !active ? "R10" : (!fits ? "R8" : (dir_v ? "R6" : "R7"));
        line_mis = 0; ovf_seen = 0;
        step(10'h3FF, 10'h3FF); step(10'h000, 10'h000); step(10'h000, 10'h000);
        step(xyz(f, 1'b1), xyz(f, 1'b1));
        for (int i = 0; i < HB; i++) step(blk[i], ex[i]);
        step(10'h3FF, 10'h3FF); step(10'h000, 10'h000); step(10'h000, 10'h000);
        step(xyz(f, 1'b0), xyz(f, 1'b0));
        for (int i = 0; i < ACT; i++) begin
            logic [9:0] a;
            a = 10'($urandom_range(4, 1019));
            step(a, a);
        end
        check(line_mis == 0, req, $sformatf("line %0d word mismatches", L), line_mis, 0);
        check(ovf_seen == int'(active && !fits), "R8", $sformatf("line %0d overflow pulses", L),
              ovf_seen, int'(active && !fits));
        check(q.size() == ((active && fits) ? 0 : n), "R9", $sformatf("line %0d words left", L),
              q.size(), (active && fits) ? 0 : n);
        g++;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd7734);
        rst = 1; vin = 0; en = 0; mode = 0; dsel = 1; ta = 2; tb = 5; bword = 0; avail = 0;
        for (int i = 0; i < 8; i++) hist[i] = 10'h000;
        repeat (4) @(negedge clk);
        check(vout == 0 && pop == 0 && ovf == 0, "R10", "reset outputs",
              int'({vout, pop, ovf}), 0);
        rst = 0;
        // R1: enable raised mid-frame; line 5 of this frame stays untouched
        for (int L = 1; L <= 6; L++) do_line(L, L >= 3, 2'b00, 1'b1, 5, 0, L == 5 ? "R1" : "");
        // R1, R6: armed from this frame on, direct placement
        for (int L = 1; L <= 6; L++) do_line(L, 1'b1, 2'b00, 1'b1, $urandom_range(1, 10), 0, "");
        // R3, R7: enable cleared, append after existing packets
        for (int L = 1; L <= 6; L++)
            do_line(L, L == 1, 2'b00, 1'b0, $urandom_range(1, 10), $urandom_range(0, 2),
                    L == 5 ? "R3" : "");
        // R8: exact fit on line 2, one word too many on line 5
        for (int L = 1; L <= 6; L++)
            do_line(L, 1'b0, 2'b00, 1'b1, L == 2 ? HB : (L == 5 ? HB + 1 : 3), 0, "R8");
        // R4: bypass keeps stream unchanged and reads nothing
        for (int L = 1; L <= 6; L++) do_line(L, 1'b1, 2'b11, 1'b1, 5, 1, "R4");
        // R5: leave bypass; line 2 is inside the hold-off, line 5 after it
        for (int L = 1; L <= 6; L++) do_line(L, 1'b1, 2'b00, 1'b1, 6, 0, "R5");
        // R2: other target lines, checked in append mode
        ta = 1; tb = 6;
        for (int L = 1; L <= 6; L++) do_line(L, 1'b1, 2'b00, 1'b0, 4, 2, "R2");
        // R9: random frames
        for (int fr = 0; fr < 14; fr++) begin
            ta = LW'($urandom_range(1, 6));
            tb = LW'($urandom_range(1, 6));
            for (int L = 1; L <= 6; L++)
                do_line(L, 1'($urandom_range(0, 1)), 2'b00, 1'($urandom_range(0, 1)),
                        $urandom_range(0, 24), $urandom_range(0, 2), "");
        end
        line_mis = 0;
        for (int i = 0; i < 6; i++) step(10'h200, 10'h200);
        check(line_mis == 0, "R10", "tail word mismatches", line_mis, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule